// File: doc/BRIEF.md
# Subvector Transpose Index Generator

This block produces the offset pairs for an element-by-element vector move whose elements are grouped into subvectors of one to four members. A vector of `vl` groups, each `subvl_m1 + 1` members long, holds `vl * (subvl_m1 + 1)` elements. The element at group `i`, member `j` lives at offset `i * S + j`, where S is the subvector length. Each side of the move (source and destination) has its own walker. A walker visits the elements either group by group, which is the natural order, or member by member across all groups, which is the transposed order. When the two sides use different orders, the move regroups the elements, either gathering like members together or spreading them back out.

A pulse on `start` while the block is idle latches the configuration. One offset pair is then presented per accepted handshake (`valid` and `ready` both high). Both walkers step together on every accepted pair. A single-cycle `done` marks the end of the run. The `pack` input transposes the source walk and `unpack` transposes the destination walk. Setting both is allowed and gives a deterministic result.

Top module: `sidx_gen`

## Requirements
- R1: While reset is asserted and immediately after it, `valid` and `done` are low.
- R2: A `start` pulse seen while idle latches `vl`, `subvl_m1`, `pack` and `unpack`. For `vl` of at least 1, `valid` is high in the next cycle with both offsets equal to 0.
- R3: In the natural order the walk goes group-outer and member-inner. The offsets produced are 0, 1, 2 and so on up to `vl*S-1`, where S = `subvl_m1`+1 (field value 0 to 3 meaning length 1 to 4).
- R4: In the transposed order the walk goes member-outer and group-inner, and step k produces offset `(k mod vl)*S + (k div vl)`. For vl=2 and S=3 this gives 0,3,1,4,2,5.
- R5: `pack`=1 selects the transposed order for the source offset and `unpack`=1 selects it for the destination offset, each independently. When both are set, both sides follow the transposed order.
- R6: Each accepted handshake advances both walkers by exactly one step. A run presents exactly `vl*S` pairs.
- R7: While `valid` is high and `ready` is low, both offsets and `valid` hold their values.
- R8: `done` is high for exactly one cycle, in the cycle after the final pair is accepted, and `valid` is low in that cycle.
- R9: A start with `vl`=0 presents no pairs, and `done` rises in the next cycle.
- R10: A `start` pulse while `valid` or `done` is high is ignored, and the running sequence continues unchanged.
- R11: With S=1 both orders produce the offsets 0 to `vl`-1 in increasing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the presented configuration |
| vl | input | VL_W | Number of subvector groups, 0..MAX_VL |
| subvl_m1 | input | 2 | Subvector length minus one |
| pack | input | 1 | Transpose the source walk |
| unpack | input | 1 | Transpose the destination walk |
| ready | input | 1 | Consumer accepts the current pair |
| src_off | output | OFF_W | Source element offset |
| dst_off | output | OFF_W | Destination element offset |
| valid | output | 1 | Offset pair is presented |
| done | output | 1 | One-cycle end-of-run marker |

## Verification
The assertions assume that `vl` never exceeds MAX_VL. They also assume that `ready` is only meaningful while `valid` is high, so the hold property is checked only for cycles in which the block itself presents a pair. The stimulus keeps every `vl` within 0..16, changes configuration inputs only alongside a `start` pulse, and drives `ready` low on a fixed period to exercise stalls. One directed run pulses `start` mid-sequence with a different length, to show that an active run ignores it.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  typedef enum logic {
    ORD_GROUP_OUTER  = 1'b0,
    ORD_MEMBER_OUTER = 1'b1
  } walk_order_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } run_state_e;

  localparam int MAX_SUBLEN = 4;
endpackage

// File: rtl/sidx_walker.sv
module sidx_walker
  import sidx_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int OFF_W = $clog2(MAX_VL * MAX_SUBLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [VL_W-1:0]   vl_q,
  input  logic [2:0]        slen_q,
  input  walk_order_e       order,
  output logic [OFF_W-1:0]  off,
  output logic              last
);
  logic [VL_W-1:0] grp_q, grp_d;
  logic [2:0]      mem_q, mem_d;
  logic            grp_end, mem_end;

  assign grp_end = (grp_q == vl_q - VL_W'(1));
  assign mem_end = (mem_q == slen_q - 3'd1);
  assign last    = grp_end && mem_end;
  assign off     = OFF_W'(grp_q) * OFF_W'(slen_q) + OFF_W'(mem_q);

  always_comb begin
    grp_d = grp_q;
    mem_d = mem_q;
    if (load) begin
      grp_d = '0;
      mem_d = '0;
    end else if (step) begin
      if (order == ORD_MEMBER_OUTER) begin
        if (grp_end) begin
          grp_d = '0;
          mem_d = mem_q + 3'd1;
        end else begin
          grp_d = grp_q + VL_W'(1);
        end
      end else begin
        if (mem_end) begin
          mem_d = '0;
          grp_d = grp_q + VL_W'(1);
        end else begin
          mem_d = mem_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      mem_q <= '0;
    end else if (load || step) begin
      grp_q <= grp_d;
      mem_q <= mem_d;
    end
  end

  AST_WALK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (off != $past(off)));  // R6
endmodule

// File: rtl/sidx_ctrl.sv
module sidx_ctrl
  import sidx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic vl_zero,
  input  logic last,
  input  logic ready,
  output logic valid,
  output logic done,
  output logic load,
  output logic step
);
  run_state_e st_q, st_d;

  assign valid = (st_q == ST_RUN);
  assign done  = (st_q == ST_FIN);
  assign load  = (st_q == ST_IDLE) && start;
  assign step  = (st_q == ST_RUN) && ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = vl_zero ? ST_FIN : ST_RUN;
      ST_RUN:  if (ready && last) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !done && start && !vl_zero) |=> valid);  // R2
  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !done && start && vl_zero) |=> (done && !valid));  // R9
endmodule

// File: rtl/sidx_gen.sv
module sidx_gen
  import sidx_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int OFF_W = $clog2(MAX_VL * MAX_SUBLEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vl,
  input  logic [1:0]       subvl_m1,
  input  logic             pack,
  input  logic             unpack,
  input  logic             ready,
  output logic [OFF_W-1:0] src_off,
  output logic [OFF_W-1:0] dst_off,
  output logic             valid,
  output logic             done
);
  localparam int SIDES = 2;

  logic [VL_W-1:0] vl_q;
  logic [2:0]      slen_q;
  logic            pack_q, unpack_q;
  logic            load, step;
  logic [OFF_W-1:0] side_off  [SIDES];
  logic             side_last [SIDES];
  walk_order_e      side_ord  [SIDES];
  logic [OFF_W-1:0] total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q     <= '0;
      slen_q   <= 3'd1;
      pack_q   <= 1'b0;
      unpack_q <= 1'b0;
    end else if (load) begin
      vl_q     <= vl;
      slen_q   <= {1'b0, subvl_m1} + 3'd1;
      pack_q   <= pack;
      unpack_q <= unpack;
    end
  end

  assign side_ord[0] = pack_q   ? ORD_MEMBER_OUTER : ORD_GROUP_OUTER;
  assign side_ord[1] = unpack_q ? ORD_MEMBER_OUTER : ORD_GROUP_OUTER;

  sidx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vl_zero (vl == '0),
    .last    (side_last[0]),
    .ready   (ready),
    .valid   (valid),
    .done    (done),
    .load    (load),
    .step    (step)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    sidx_walker #(.MAX_VL(MAX_VL)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .vl_q   (vl_q),
      .slen_q (slen_q),
      .order  (side_ord[s]),
      .off    (side_off[s]),
      .last   (side_last[s])
    );
  end

  assign src_off = side_off[0];
  assign dst_off = side_off[1];
  assign total   = OFF_W'(vl_q) * OFF_W'(slen_q);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(src_off) && $stable(dst_off)));  // R7
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (side_last[0] == side_last[1]));  // R6
  AST_SAME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (pack_q == unpack_q)) |-> (src_off == dst_off));  // R5
  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((src_off < total) && (dst_off < total)));  // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && done));  // R8
endmodule

// File: tb/sidx_gen_bench.sv
module sidx_gen_bench;
  localparam int MAX_VL = 16;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int OFF_W  = $clog2(MAX_VL * 4 + 1);
  localparam int NCFG   = 8;
  // columns: vl, sublen, pack, unpack, stall
  localparam int CFG [NCFG][5] = '{
    '{2, 3, 1, 0, 0},
    '{2, 3, 0, 1, 1},
    '{4, 4, 1, 1, 0},
    '{3, 2, 0, 0, 1},
    '{5, 1, 1, 0, 0},
    '{1, 4, 1, 0, 1},
    '{16, 4, 0, 1, 1},
    '{7, 3, 1, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] vl = '0;
  logic [1:0] subvl_m1 = '0;
  logic pack = 1'b0, unpack = 1'b0, ready = 1'b0;
  logic [OFF_W-1:0] src_off, dst_off;
  logic valid, done;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sidx_gen #(.MAX_VL(MAX_VL)) u_sidx_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl_m1(subvl_m1),
    .pack(pack), .unpack(unpack), .ready(ready), .src_off(src_off),
    .dst_off(dst_off), .valid(valid), .done(done)
  );

  function automatic int exp_off(int k, int n_vl, int s, bit tr);
    return tr ? (k % n_vl) * s + (k / n_vl) : k;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_cfg(int n_vl, int s, bit p, bit u, bit stall, bit inj, string req);
    int k = 0;
    int cyc = 0;
    int n = n_vl * s;
    @(negedge clk);
    vl = VL_W'(n_vl); subvl_m1 = 2'(s - 1); pack = p; unpack = u;
    start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (n_vl == 0) begin
      check("R9 done", int'(done), 1);
      check("R9 valid", int'(valid), 0);
      @(negedge clk);
      check("R9 done drop", int'(done), 0);
      return;
    end
    check("R2 first src", int'(src_off), 0);
    check("R2 first dst", int'(dst_off), 0);
    while (k < n && cyc < 2000) begin
      check({req, " R6 valid"}, int'(valid), 1);
      // R10: a second start mid-run must change nothing
      if (inj && cyc == 2) begin
        start = 1'b1; vl = VL_W'(1); subvl_m1 = 2'd0; pack = ~p; unpack = ~u;
      end else begin
        start = 1'b0;
      end
      ready = stall ? (cyc % 3 != 2) : 1'b1;
      // R7: while stalled the same pair k is still expected
      check({req, " src"}, int'(src_off), exp_off(k, n_vl, s, p));
      check({req, " dst"}, int'(dst_off), exp_off(k, n_vl, s, u));
      if (ready) k++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; ready = 1'b0;
    check({req, " R8 done"}, int'(done), 1);
    check({req, " R8 valid low"}, int'(valid), 0);
    @(negedge clk);
    check({req, " R8 pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(valid), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid post", int'(valid), 0);
    check("R1 done post", int'(done), 0);
    // R3 R4 R5 R11 table walk
    for (int t = 0; t < NCFG; t++) begin
      run_cfg(CFG[t][0], CFG[t][1], CFG[t][2][0], CFG[t][3][0], CFG[t][4][0], 1'b0,
              "R3/R4/R5/R11");
    end
    // R4 example with transposed source only
    run_cfg(2, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R4 example");
    // R9 zero length
    run_cfg(0, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R10 start during a run
    run_cfg(3, 3, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
    // R11 unit length, both orders
    run_cfg(6, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule